// File: doc/BRIEF.md
# Split Three-Input Boolean Data Unit

This block is the result path of a small pixel-processing core. Each issued operation takes up to three operands and forms one result, which lands in a destination register only when a condition test on the core's status flags succeeds. The available operations are a truth-table Boolean of three inputs (any of the 256 functions), an add or subtract that can be cut into independent byte, halfword or word lanes, a left rotate, a bit-field merge steered by a lane mask grown from a few mask-flag bits, and an AND with a low-order run of ones.

The second operand can be swapped for an alternate operand according to the negative status bit, which lets a single operation pick between two candidates without a branch. Lane carry and lane zero flags are registered with the result, so the surrounding core can test per-lane outcomes of split arithmetic.

Top module: `split_bool_du`

## Requirements
- R1: While rst_n is low, dst_q, lane_co and lane_z are all zero.
- R2: With op=0 (Boolean), result bit i equals tt_code[{opd_a[i], B[i], opd_c[i]}], where B is the selected second operand; so code 0x96 gives the three-way XOR and 0xE8 the majority.
- R3: op=1 adds and op=2 subtracts (A + ~B + 1) inside lanes chosen by lane_sz (0 = byte, 1 = halfword, 2 or 3 = word); no carry crosses a lane boundary.
- R4: lane_co bit k is the carry-out (for subtract: no borrow) of the lane whose top byte is byte k, and is 0 for every other byte and for all non-arithmetic operations; lane_z bit k is 1 when the whole lane holding byte k of the result is zero.
- R5: op=5 returns opd_a AND a mask whose mgen_n low bits are ones; mgen_n=0 gives zero, mgen_n of 32 or more keeps all of opd_a, mgen_n=7 gives mask 0x0000007F.
- R6: op=4 returns (opd_a & M) | (B & ~M), where every byte of M is 0xFF when mflags[byte / lane size in bytes] is 1; byte size with mflags=0x3 gives M=0x0000FFFF, word size uses only mflags[0].
- R7: op=3 returns opd_a rotated left by rot_amt bits.
- R8: With csel_en=1, B is opd_b when n_flag=1 and opd_c when n_flag=0; with csel_en=0, B is opd_b.
- R9: A result and flags are written only when issue is 1 and cond holds: 0 always, 1 Z, 2 not Z, 3 N xor V (less than), 4 not (N xor V), 5 C, 6 not C, 7 never; otherwise all outputs hold.
- R10: Operation codes 6 and 7 write a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation select |
| cond | input | 3 | Condition code for the write |
| st_n | input | 1 | Negative status bit |
| st_z | input | 1 | Zero status bit |
| st_c | input | 1 | Carry status bit |
| st_v | input | 1 | Overflow status bit |
| opd_a | input | 32 | First operand |
| opd_b | input | 32 | Second operand |
| opd_c | input | 32 | Third operand, also alternate second operand |
| csel_en | input | 1 | Enable conditional source selection |
| n_flag | input | 1 | Flag steering the source selection |
| tt_code | input | 8 | Truth table of the Boolean operation |
| lane_sz | input | 2 | Lane size for split arithmetic, merge and zero flags |
| mflags | input | 4 | Mask-flag bits for the expander |
| rot_amt | input | 5 | Left rotate amount |
| mgen_n | input | 6 | Count of low-order ones for the mask generator |
| dst_q | output | 32 | Destination register |
| lane_co | output | 4 | Per-lane carry-out flags |
| lane_z | output | 4 | Per-lane zero flags |

## Verification
Source selection and the condition test act in the same cycle: the bench issues split adds and merges with csel_en set while the condition code is decided by status flags that are also toggled, so a wrong operand choice and a wrongly suppressed or allowed write would each show. Directed cases pair source selection with a failing less-than test and expect the earlier result to survive, then with a passing one and expect the alternate operand's sum. A behavioural model fed the same inputs judges the result and both flag vectors after every clock, across a long run of mixed operations, lane sizes and conditions.

// File: rtl/du_pkg.sv
package du_pkg;
   typedef enum logic [2:0] {
      OP_BOOL  = 3'd0,
      OP_ADD   = 3'd1,
      OP_SUB   = 3'd2,
      OP_ROT   = 3'd3,
      OP_MERGE = 3'd4,
      OP_MASK  = 3'd5
   } du_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } du_sz_e;

   function automatic logic du_cond_ok(input logic [2:0] cc, input logic n, input logic z,
                                       input logic c, input logic v);
      logic ok;
      case (cc)
         3'd0: ok = 1'b1;
         3'd1: ok = z;
         3'd2: ok = ~z;
         3'd3: ok = n ^ v;
         3'd4: ok = ~(n ^ v);
         3'd5: ok = c;
         3'd6: ok = ~c;
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction
endpackage

// File: rtl/du_bool3.sv
module du_bool3 #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic [WIDTH-1:0] w,
   input  logic [7:0]       code,
   output logic [WIDTH-1:0] f
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign f[i] = code[{x[i], y[i], w[i]}];
   end
endmodule

// File: rtl/du_lane_add.sv
module du_lane_add import du_pkg::*; #(
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8,
   localparam int NL    = WIDTH / LANE_W
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             sub,
   input  logic [1:0]       sz,
   output logic [WIDTH-1:0] sum,
   output logic [NL-1:0]    co
);
   logic          sz_byte, sz_half;
   logic [NL-1:0] cout;

   assign sz_byte = (sz == SZ_BYTE);
   assign sz_half = (sz == SZ_HALF);

   for (genvar k = 0; k < NL; k++) begin : g_lane
      localparam bit EVEN = (k % 2) == 0;
      localparam bit LAST = (k == NL - 1);
      logic              start, fin, cin;
      logic [LANE_W-1:0] yb;

      assign start = sz_byte | (sz_half & EVEN) | (k == 0);
      assign fin   = sz_byte | (sz_half & ~EVEN) | LAST;
      assign yb    = y[k*LANE_W +: LANE_W] ^ {LANE_W{sub}};

      if (k == 0) begin : g_first
         assign cin = sub;
      end else begin : g_chain
         assign cin = start ? sub : cout[k-1];
      end

      assign {cout[k], sum[k*LANE_W +: LANE_W]} =
         {1'b0, x[k*LANE_W +: LANE_W]} + {1'b0, yb} + {{LANE_W{1'b0}}, cin};
      assign co[k] = fin & cout[k];
   end
endmodule

// File: rtl/du_mask_unit.sv
module du_mask_unit import du_pkg::*; #(
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8,
   localparam int NL    = WIDTH / LANE_W,
   localparam int NW    = $clog2(WIDTH) + 1
) (
   input  logic [NW-1:0]    cnt,
   input  logic [NL-1:0]    flags,
   input  logic [1:0]       sz,
   output logic [WIDTH-1:0] ones,
   output logic [WIDTH-1:0] xmask
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_ones
      assign ones[i] = (cnt > NW'(i));
   end

   for (genvar k = 0; k < NL; k++) begin : g_exp
      logic pick;
      always_comb begin
         case (sz)
            SZ_BYTE: pick = flags[k];
            SZ_HALF: pick = flags[k/2];
            default: pick = flags[0];
         endcase
      end
      assign xmask[k*LANE_W +: LANE_W] = {LANE_W{pick}};
   end
endmodule

// File: rtl/du_rotl.sv
module du_rotl #(
   parameter int WIDTH = 32,
   localparam int RW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] x,
   input  logic [RW-1:0]    amt,
   output logic [WIDTH-1:0] y
);
   logic [WIDTH-1:0] stg [RW+1];
   assign stg[0] = x;

   for (genvar s = 0; s < RW; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stg[s+1] = amt[s] ? {stg[s][WIDTH-1-SH:0], stg[s][WIDTH-1:WIDTH-SH]} : stg[s];
   end

   assign y = stg[RW];
endmodule

// File: rtl/split_bool_du.sv
module split_bool_du import du_pkg::*; #(
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      issue,
   input  logic [2:0]                op,
   input  logic [2:0]                cond,
   input  logic                      st_n,
   input  logic                      st_z,
   input  logic                      st_c,
   input  logic                      st_v,
   input  logic [WIDTH-1:0]          opd_a,
   input  logic [WIDTH-1:0]          opd_b,
   input  logic [WIDTH-1:0]          opd_c,
   input  logic                      csel_en,
   input  logic                      n_flag,
   input  logic [7:0]                tt_code,
   input  logic [1:0]                lane_sz,
   input  logic [WIDTH/LANE_W-1:0]   mflags,
   input  logic [$clog2(WIDTH)-1:0]  rot_amt,
   input  logic [$clog2(WIDTH):0]    mgen_n,
   output logic [WIDTH-1:0]          dst_q,
   output logic [WIDTH/LANE_W-1:0]   lane_co,
   output logic [WIDTH/LANE_W-1:0]   lane_z
);
   localparam int NL = WIDTH / LANE_W;

   if ((WIDTH % (2 * LANE_W)) != 0 || NL < 2) begin : g_bad_cfg
      $error("WIDTH must hold an even number of lanes, at least two");
   end
   if ((1 << $clog2(WIDTH)) != WIDTH) begin : g_bad_width
      $error("WIDTH must be a power of two");
   end

   logic [WIDTH-1:0] b_eff, bool_y, sum_y, rot_y, ones, xmask, res;
   logic [NL-1:0]    co_add, co_nx, bz, z_nx;
   logic             arith, wr;

   assign b_eff = (csel_en && !n_flag) ? opd_c : opd_b;
   assign arith = (op == OP_ADD) || (op == OP_SUB);

   du_bool3 #(.WIDTH(WIDTH)) i_bool (
      .x(opd_a), .y(b_eff), .w(opd_c), .code(tt_code), .f(bool_y)
   );

   du_lane_add #(.WIDTH(WIDTH), .LANE_W(LANE_W)) i_add (
      .x(opd_a), .y(b_eff), .sub(op == OP_SUB), .sz(lane_sz), .sum(sum_y), .co(co_add)
   );

   du_mask_unit #(.WIDTH(WIDTH), .LANE_W(LANE_W)) i_mask (
      .cnt(mgen_n), .flags(mflags), .sz(lane_sz), .ones(ones), .xmask(xmask)
   );

   du_rotl #(.WIDTH(WIDTH)) i_rot (
      .x(opd_a), .amt(rot_amt), .y(rot_y)
   );

   always_comb begin
      case (op)
         OP_BOOL:  res = bool_y;
         OP_ADD,
         OP_SUB:   res = sum_y;
         OP_ROT:   res = rot_y;
         OP_MERGE: res = (opd_a & xmask) | (b_eff & ~xmask);
         OP_MASK:  res = opd_a & ones;
         default:  res = '0;
      endcase
   end

   assign co_nx = arith ? co_add : '0;

   for (genvar k = 0; k < NL; k++) begin : g_zero
      localparam int PR = k ^ 1;
      assign bz[k] = ~|res[k*LANE_W +: LANE_W];
      always_comb begin
         case (lane_sz)
            SZ_BYTE: z_nx[k] = bz[k];
            SZ_HALF: z_nx[k] = bz[k] & bz[PR];
            default: z_nx[k] = &bz;
         endcase
      end
   end

   assign wr = issue && du_cond_ok(cond, st_n, st_z, st_c, st_v);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_q   <= '0;
         lane_co <= '0;
         lane_z  <= '0;
      end else if (wr) begin
         dst_q   <= res;
         lane_co <= co_nx;
         lane_z  <= z_nx;
      end
   end
endmodule

// File: rtl/du_chk.sv
module du_chk #(
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8,
   localparam int NL    = WIDTH / LANE_W,
   localparam int NW    = $clog2(WIDTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue,
   input logic [2:0]       op,
   input logic [2:0]       cond,
   input logic [1:0]       lane_sz,
   input logic             mf0,
   input logic [NW-1:0]    mgen_n,
   input logic [WIDTH-1:0] opd_a,
   input logic [WIDTH-1:0] dst_q,
   input logic [NL-1:0]    lane_co
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dst_q == '0 && lane_co == '0));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> ($stable(dst_q) && $stable(lane_co)));

   // R9
   never_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 3'd7) |=> $stable(dst_q));

   // R5
   mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 3'd0 && op == 3'd5 && mgen_n == '0) |=> dst_q == '0);

   // R5
   mask_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 3'd0 && op == 3'd5 && mgen_n >= NW'(WIDTH)) |=> dst_q == $past(opd_a));

   // R4
   co_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 3'd0 && op != 3'd1 && op != 3'd2) |=> lane_co == '0);

   // R6
   word_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 3'd0 && op == 3'd4 && lane_sz == 2'd2 && mf0) |=> dst_q == $past(opd_a));

   // R3
   byte_co_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 3'd0 && lane_sz == 2'd2) |=> lane_co[NL-2:0] == '0);
endmodule

bind split_bool_du du_chk #(.WIDTH(WIDTH), .LANE_W(LANE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .cond(cond), .lane_sz(lane_sz),
   .mf0(mflags[0]), .mgen_n(mgen_n), .opd_a(opd_a), .dst_q(dst_q), .lane_co(lane_co)
);

// File: tb/test_split_bool_du.sv
module test_split_bool_du;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [2:0]  op = '0, cond = '0;
   logic        st_n = 0, st_z = 0, st_c = 0, st_v = 0;
   logic [31:0] opd_a = '0, opd_b = '0, opd_c = '0;
   logic        csel_en = 0, n_flag = 0;
   logic [7:0]  tt_code = '0;
   logic [1:0]  lane_sz = '0;
   logic [3:0]  mflags = '0;
   logic [4:0]  rot_amt = '0;
   logic [5:0]  mgen_n = '0;
   logic [31:0] dst_q;
   logic [3:0]  lane_co, lane_z;

   int    total = 0, bad = 0;
   bit    done = 0;
   string tag = "R1";
   logic [31:0] exp_q = '0;
   logic [3:0]  exp_co = '0, exp_z = '0;

   always #5 clk = ~clk;

   split_bool_du i_split_bool_du (.*);

   function automatic void ref_op(output logic [31:0] r, output logic [3:0] co,
                                  output logic [3:0] z);
      logic [31:0] be, m;
      logic [63:0] dd;
      longint msk, av, bv, s;
      int lb, w;
      be = csel_en ? (n_flag ? opd_b : opd_c) : opd_b;
      lb = (lane_sz == 0) ? 1 : (lane_sz == 1) ? 2 : 4;
      w  = 8 * lb;
      msk = (64'd1 << w) - 1;
      r = '0; co = '0; z = '0;
      case (op)
         3'd0: for (int i = 0; i < 32; i++) r[i] = tt_code[{opd_a[i], be[i], opd_c[i]}];
         3'd1, 3'd2: for (int l = 0; l < 4; l += lb) begin
            av = longint'(opd_a >> (8*l)) & msk;
            bv = longint'(be >> (8*l)) & msk;
            s  = (op == 3'd2) ? av + ((~bv) & msk) + 1 : av + bv;
            r  = r | (32'(s & msk) << (8*l));
            co[l+lb-1] = ((s >> w) & 1) != 0;
         end
         3'd3: begin dd = {opd_a, opd_a} << rot_amt; r = dd[63:32]; end
         3'd4: begin
            for (int k = 0; k < 4; k++) m[8*k +: 8] = mflags[k/lb] ? 8'hFF : 8'h00;
            r = (opd_a & m) | (be & ~m);
         end
         3'd5: begin
            m = (mgen_n >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << mgen_n) - 1);
            r = opd_a & m;
         end
         default: r = '0;
      endcase
      for (int l = 0; l < 4; l += lb)
         for (int k = l; k < l + lb; k++) z[k] = ((longint'(r >> (8*l)) & msk) == 0);
   endfunction

   function automatic bit cond_pass();
      case (cond)
         3'd0: return 1;
         3'd1: return st_z;
         3'd2: return !st_z;
         3'd3: return st_n != st_v;
         3'd4: return st_n == st_v;
         3'd5: return st_c;
         3'd6: return !st_c;
         default: return 0;
      endcase
   endfunction

   // reference model, updated at each rising edge
   always @(posedge clk) begin
      logic [31:0] r;
      logic [3:0]  co, z;
      if (!rst_n) begin
         exp_q <= '0; exp_co <= '0; exp_z <= '0;
      end else if (issue && cond_pass()) begin
         ref_op(r, co, z);
         exp_q <= r; exp_co <= co; exp_z <= z;
      end
   end

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", t, act, exp);
      end
   endtask

   // compare against the model on every clock, away from the edge
   always @(negedge clk) if (rst_n && !done) begin
      chk(tag, dst_q, exp_q);
      chk("R4 lane_co", {28'd0, lane_co}, {28'd0, exp_co});
      chk("R4 lane_z", {28'd0, lane_z}, {28'd0, exp_z});
   end

   task automatic run(input string t, input logic [2:0] o, input logic [2:0] cc,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      tag = t; op = o; cond = cc; opd_a = a; opd_b = b; opd_c = c; issue = 1;
      @(negedge clk);
      issue = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset q", dst_q, 0);
      chk("R1 reset flags", {24'd0, lane_co, lane_z}, 0);
      rst_n = 1;

      // R2 truth-table Boolean
      tt_code = 8'h96;
      run("R2", 0, 0, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA);
      chk("R2 xor3", dst_q, 32'h96969696);
      tt_code = 8'hE8;
      run("R2", 0, 0, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA);
      chk("R2 majority", dst_q, 32'hE8E8E8E8);

      // R3 split add and subtract
      lane_sz = 0;
      run("R3", 1, 0, 32'h80FF0102, 32'h80010203, 0);
      chk("R3 byte add", dst_q, 32'h00000305);
      chk("R4 byte co", {28'd0, lane_co}, 4'b1100);
      chk("R4 byte z", {28'd0, lane_z}, 4'b1100);
      lane_sz = 1;
      run("R3", 1, 0, 32'h0000FFFF, 32'h00000001, 0);
      chk("R3 half add", dst_q, 0);
      chk("R4 half co", {28'd0, lane_co}, 4'b0010);
      chk("R4 half z", {28'd0, lane_z}, 4'b1111);
      lane_sz = 2;
      run("R3", 1, 0, 32'h0000FFFF, 32'h00000001, 0);
      chk("R3 word add", dst_q, 32'h00010000);
      lane_sz = 0;
      run("R3", 2, 0, 32'h00050310, 32'h01050210, 0);
      chk("R3 byte sub", dst_q, 32'hFF000100);
      chk("R4 sub co", {28'd0, lane_co}, 4'b0111);
      chk("R4 sub z", {28'd0, lane_z}, 4'b0101);

      // R5 mask generator
      mgen_n = 7;  run("R5", 5, 0, 32'hFFFFFFFF, 0, 0); chk("R5 n=7", dst_q, 32'h7F);
      mgen_n = 0;  run("R5", 5, 0, 32'hFFFFFFFF, 0, 0); chk("R5 n=0", dst_q, 0);
      mgen_n = 31; run("R5", 5, 0, 32'hFFFFFFFF, 0, 0); chk("R5 n=31", dst_q, 32'h7FFFFFFF);
      mgen_n = 40; run("R5", 5, 0, 32'hFFFFFFFF, 0, 0); chk("R5 n=40", dst_q, 32'hFFFFFFFF);

      // R6 expander and merge
      lane_sz = 0; mflags = 4'h3;
      run("R6", 4, 0, 32'h11223344, 32'hAABBCCDD, 0); chk("R6 byte", dst_q, 32'hAABB3344);
      lane_sz = 1; mflags = 4'b0010;
      run("R6", 4, 0, 32'h11223344, 32'hAABBCCDD, 0); chk("R6 half", dst_q, 32'h1122CCDD);
      lane_sz = 2; mflags = 4'hE;
      run("R6", 4, 0, 32'h11223344, 32'hAABBCCDD, 0); chk("R6 word", dst_q, 32'hAABBCCDD);

      // R7 rotate
      rot_amt = 1; run("R7", 3, 0, 32'h80000001, 0, 0); chk("R7 by1", dst_q, 32'h00000003);
      rot_amt = 4; run("R7", 3, 0, 32'h12345678, 0, 0); chk("R7 by4", dst_q, 32'h23456781);

      // R8 source selection, R9 condition in the same cycle
      lane_sz = 2; csel_en = 1; n_flag = 1;
      run("R8", 1, 0, 10, 5, 100); chk("R8 n=1", dst_q, 15);
      n_flag = 0; st_n = 1; st_v = 1;
      run("R9", 1, 3, 10, 5, 100); chk("R9 lt fails", dst_q, 15);
      st_v = 0;
      run("R8", 1, 3, 10, 5, 100); chk("R8 n=0 lt", dst_q, 110);
      run("R9", 2, 7, 10, 5, 100); chk("R9 never", dst_q, 110);
      csel_en = 0;
      run("R8", 1, 0, 10, 5, 100); chk("R8 off", dst_q, 15);

      // R10 unused op codes
      run("R10", 6, 0, 32'h1234, 5, 7); chk("R10 op6", dst_q, 0);

      // mixed traffic judged by the model
      for (int i = 0; i < 400; i++) begin
         tt_code = 8'($urandom); lane_sz = 2'($urandom); mflags = 4'($urandom);
         rot_amt = 5'($urandom); mgen_n = 6'($urandom); csel_en = 1'($urandom);
         n_flag = 1'($urandom); {st_n, st_z, st_c, st_v} = 4'($urandom);
         if ($urandom % 4 != 0)
            run("R2 R3 R5 R6 R7 R8 R9 random", 3'($urandom), 3'($urandom),
                $urandom, $urandom, $urandom);
         else begin
            tag = "R9 idle"; @(negedge clk);
         end
      end
      finish_run();
   end
endmodule